// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised set of shared interrupt inputs (32 by default) and turns them into a small set of CPU interrupt pins plus one non-maskable interrupt line. Each input is first passed through a two-flop synchroniser. It is then qualified by its own settings: polarity, level or edge trigger, and single or dual edge. Edge sources hold their event in a sticky latch. Software sets or clears that latch through one trigger register, which carries a set/clear flag and a source number.

Every source has an enable mask. Software changes the mask only through two write-one-to-act registers, one that sets enables and one that clears them, and can read the result back. A source that is pending and enabled drives the CPU pin named in its routing word, the non-maskable line, or both. Software reaches all state through a plain 32-bit register port with a write strobe and a combinational read path. Outputs are registered.

Top module: `shirq_ctrl`

## Requirements
- R1: After reset the mask word at 0x140 reads 0, the polarity word at 0x000 reads all ones (active high), the trigger, dual and routing words read 0, and `irq_pin` and `irq_nmi` are low.
- R2: With trigger bit 0 (level), a source is pending while its synchronised input equals its polarity bit (1 = active high, 0 = active low). The pending word is at 0x180.
- R3: With trigger bit 1 (edge) and dual bit 0, a rising input transition latches the source pending when polarity is 1, and a falling one does when polarity is 0. The opposite transition does not latch it.
- R4: With trigger bit 1 and dual bit 1, both rising and falling transitions latch the source pending, whatever the polarity.
- R5: A write to 0x1C0 with bit 31 = 1 sets, and with bit 31 = 0 clears, the edge latch of the source numbered in bits 7:0. A source number at or above the source count has no effect.
- R6: Writing a word to 0x0C0 enables every source whose bit is 1. Writing a word to 0x100 disables every source whose bit is 1. Zero bits leave the mask unchanged. The current mask reads at 0x140.
- R7: Every bit-per-source register (polarity 0x000, trigger 0x040, dual 0x080, mask 0x140, pending 0x180) holds source n at bit n mod 32 of word n/32, with words 4 bytes apart. Words past the last source read as 0.
- R8: The routing word of source n is at 0x400 + 4n. When bit 31 is set, CPU pin bits 5:0 is driven while the source is pending and enabled. A pin number at or above the pin count drives no pin.
- R9: `irq_nmi` is driven while any source whose routing bit 30 is set is pending and enabled.
- R10: If a hardware edge on a source arrives in the same cycle as a software clear of its latch, the latch stays set.
- R11: The mask gates only the outputs. A disabled source still shows its pending state at 0x180.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_SRC | Asynchronous shared interrupt inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 11 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| irq_pin | output | NUM_PINS | CPU interrupt pins |
| irq_nmi | output | 1 | Non-maskable interrupt |

## Verification
Two events can fall in the same cycle: an edge arriving from the synchroniser that latches a source, and a software clear of that same latch through the trigger register. The bench drives the input on a falling clock edge. It then places the clear write exactly in the cycle in which the synchronised edge becomes visible, two clock edges later, so that the set and the clear collide at one register update. The result is judged by reading the pending word: the bit must remain 1. A later clear with no edge present must bring it to 0.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
   localparam int ADDR_W = 11;

   typedef enum logic [3:0] {
      RG_POL  = 4'd0,
      RG_TRIG = 4'd1,
      RG_DUAL = 4'd2,
      RG_MSET = 4'd3,
      RG_MCLR = 4'd4,
      RG_MASK = 4'd5,
      RG_PEND = 4'd6,
      RG_SWE  = 4'd7
   } region_e;

   localparam int SWE_SET_BIT = 31;
   localparam int RT_PIN_BIT  = 31;
   localparam int RT_NMI_BIT  = 30;

   typedef struct packed {
      logic       to_pin;
      logic       to_nmi;
      logic [5:0] pin;
   } route_t;
endpackage

// File: rtl/shirq_sync.sv
module shirq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] pipe [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q      = pipe[STAGES-1];
   assign q_prev = pipe[STAGES];
endmodule

// File: rtl/shirq_src.sv
module shirq_src (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic lvl_prev,
   input  logic pol,
   input  logic trig,
   input  logic dual,
   input  logic sw_set,
   input  logic sw_clr,
   output logic pend
);
   logic rise, fall, hit, latch_q;

   assign rise = lvl & ~lvl_prev;
   assign fall = ~lvl & lvl_prev;
   assign hit  = trig & (dual ? (rise | fall) : (pol ? rise : fall));

   // a captured edge outranks a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                latch_q <= 1'b0;
      else if (hit || sw_set)    latch_q <= 1'b1;
      else if (sw_clr)           latch_q <= 1'b0;
   end

   assign pend = trig ? latch_q : (lvl == pol);
endmodule

// File: rtl/shirq_route.sv
module shirq_route
   import shirq_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_PINS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  active,
   input  route_t              route [NUM_SRC],
   output logic [NUM_PINS-1:0] pin_out,
   output logic                nmi_out
);
   logic [NUM_PINS-1:0] pin_n;
   logic                nmi_n;

   always_comb begin
      pin_n = '0;
      nmi_n = 1'b0;
      for (int n = 0; n < NUM_SRC; n++) begin
         if (active[n]) begin
            if (route[n].to_nmi) nmi_n = 1'b1;
            for (int p = 0; p < NUM_PINS; p++)
               if (route[n].to_pin && route[n].pin == 6'(p)) pin_n[p] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= '0;
         nmi_out <= 1'b0;
      end else begin
         pin_out <= pin_n;
         nmi_out <= nmi_n;
      end
   end
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
   import shirq_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int NUM_PINS    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_in,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PINS-1:0] irq_pin,
   output logic                irq_nmi
);
   localparam int NW   = (NUM_SRC + 31) / 32;
   localparam int PADW = NW * 32;

   if (NUM_SRC < 1 || NUM_SRC > 256) begin : g_bad_src
      $error("NUM_SRC must lie in 1..256");
   end
   if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, mask_q;
   logic [NUM_SRC-1:0] lvl, lvl_prev, pend, sw_set, sw_clr;
   route_t             route_q [NUM_SRC];

   logic       is_route, swe_hit;
   logic [3:0] rg_code, widx;
   logic [7:0] ridx;
   logic       unused_addr;

   assign is_route    = bus_addr[10];
   assign rg_code     = bus_addr[9:6];
   assign widx        = bus_addr[5:2];
   assign ridx        = bus_addr[9:2];
   assign unused_addr = ^bus_addr[1:0];

   shirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl), .q_prev(lvl_prev)
   );

   // software edge decode
   assign swe_hit = bus_we && !is_route && rg_code == RG_SWE;
   always_comb begin
      for (int n = 0; n < NUM_SRC; n++) begin
         sw_set[n] = swe_hit && bus_wdata[7:0] == 8'(n) &&  bus_wdata[SWE_SET_BIT];
         sw_clr[n] = swe_hit && bus_wdata[7:0] == 8'(n) && !bus_wdata[SWE_SET_BIT];
      end
   end

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      shirq_src u_src (
         .clk(clk), .rst_n(rst_n), .lvl(lvl[n]), .lvl_prev(lvl_prev[n]),
         .pol(pol_q[n]), .trig(trig_q[n]), .dual(dual_q[n]),
         .sw_set(sw_set[n]), .sw_clr(sw_clr[n]), .pend(pend[n])
      );
   end

   // configuration and mask registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '1;
         trig_q <= '0;
         dual_q <= '0;
         mask_q <= '0;
         for (int n = 0; n < NUM_SRC; n++) route_q[n] <= '0;
      end else if (bus_we) begin
         if (is_route) begin
            for (int n = 0; n < NUM_SRC; n++)
               if (ridx == 8'(n))
                  route_q[n] <= '{to_pin: bus_wdata[RT_PIN_BIT],
                                  to_nmi: bus_wdata[RT_NMI_BIT],
                                  pin:    bus_wdata[5:0]};
         end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
               if (widx == 4'(i / 32)) begin
                  case (rg_code)
                     RG_POL:  pol_q[i]  <= bus_wdata[i % 32];
                     RG_TRIG: trig_q[i] <= bus_wdata[i % 32];
                     RG_DUAL: dual_q[i] <= bus_wdata[i % 32];
                     RG_MSET: if (bus_wdata[i % 32]) mask_q[i] <= 1'b1;
                     RG_MCLR: if (bus_wdata[i % 32]) mask_q[i] <= 1'b0;
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   // read path
   function automatic logic [31:0] pick(input logic [PADW-1:0] v, input logic [3:0] w);
      pick = '0;
      for (int k = 0; k < NW; k++)
         if (w == 4'(k)) pick = v[k*32 +: 32];
   endfunction

   always_comb begin
      bus_rdata = '0;
      if (is_route) begin
         for (int n = 0; n < NUM_SRC; n++)
            if (ridx == 8'(n))
               bus_rdata = {route_q[n].to_pin, route_q[n].to_nmi, 24'b0, route_q[n].pin};
      end else begin
         case (rg_code)
            RG_POL:  bus_rdata = pick(PADW'(pol_q),  widx);
            RG_TRIG: bus_rdata = pick(PADW'(trig_q), widx);
            RG_DUAL: bus_rdata = pick(PADW'(dual_q), widx);
            RG_MASK: bus_rdata = pick(PADW'(mask_q), widx);
            RG_PEND: bus_rdata = pick(PADW'(pend),   widx);
            default: bus_rdata = '0;
         endcase
      end
   end

   shirq_route #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) u_route (
      .clk(clk), .rst_n(rst_n), .active(pend & mask_q), .route(route_q),
      .pin_out(irq_pin), .nmi_out(irq_nmi)
   );
endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk
   import shirq_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_PINS = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic [NUM_SRC-1:0]  mask_q,
   input logic [NUM_SRC-1:0]  pend,
   input logic [NUM_PINS-1:0] irq_pin,
   input logic                irq_nmi
);
   logic [NUM_SRC-1:0] setv, clrv;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         setv[i] = bus_we && !bus_addr[10] && bus_addr[9:6] == RG_MSET &&
                   bus_addr[5:2] == 4'(i / 32) && bus_wdata[i % 32];
         clrv[i] = bus_we && !bus_addr[10] && bus_addr[9:6] == RG_MCLR &&
                   bus_addr[5:2] == 4'(i / 32) && bus_wdata[i % 32];
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_pin == '0 && !irq_nmi)); // R1
   AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|setv) |=> ((mask_q & $past(setv)) == $past(setv))); // R6
   AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|clrv) |=> ((mask_q & $past(clrv)) == '0)); // R6
   AST_PIN_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pin) |-> $past(|(pend & mask_q))); // R8
   AST_NMI_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_nmi |-> $past(|(pend & mask_q))); // R9
endmodule

bind shirq_ctrl shirq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .mask_q(mask_q), .pend(pend),
   .irq_pin(irq_pin), .irq_nmi(irq_nmi)
);

// File: tb/shirq_ctrl_test.sv
`timescale 1ns/1ps
module shirq_ctrl_test;
   localparam int NSRC  = 32;
   localparam int NPINS = 6;
   localparam logic [10:0] A_POL = 11'h000, A_TRIG = 11'h040, A_DUAL = 11'h080,
                           A_MSET = 11'h0C0, A_MCLR = 11'h100, A_MASK = 11'h140,
                           A_PEND = 11'h180, A_SWE = 11'h1C0, A_ROUTE = 11'h400;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NSRC-1:0]  irq_in = '0;
   logic             bus_we = 1'b0;
   logic [10:0]      bus_addr = '0;
   logic [31:0]      bus_wdata = '0;
   logic [31:0]      bus_rdata;
   logic [NPINS-1:0] irq_pin;
   logic             irq_nmi;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   shirq_ctrl #(.NUM_SRC(NSRC), .NUM_PINS(NPINS)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pin(irq_pin), .irq_nmi(irq_nmi)
   );

   // {pol, trig, dual, in_a, in_b, expected pending}
   localparam logic [5:0] VEC [11] = '{
      6'b100_01_1, 6'b100_10_0, 6'b000_10_1, 6'b000_01_0,
      6'b110_01_1, 6'b110_10_0, 6'b010_10_1, 6'b010_01_0,
      6'b011_01_1, 6'b111_10_1, 6'b011_00_0
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      settle(3);
      rst_n = 1'b1;
      settle(2);

      // R1 reset state
      rd(A_MASK, r);           chk("R1 mask", r, 32'h0);
      rd(A_POL, r);            chk("R1 polarity", r, 32'hFFFF_FFFF);
      rd(A_TRIG, r);           chk("R1 trigger", r, 32'h0);
      rd(A_ROUTE + 11'd12, r); chk("R1 route", r, 32'h0);
      rd(A_PEND, r);           chk("R1 pending", r, 32'h0);
      chk("R1 outputs", {25'b0, irq_nmi, irq_pin}, 32'h0);

      // vector table on source 3, routed to pin 2 and enabled
      wr(A_MSET, 32'h8);
      wr(A_ROUTE + 11'd12, 32'h8000_0002);
      for (int v = 0; v < 11; v++) begin
         logic [5:0] e;
         e = VEC[v];
         irq_in[3] = e[2];
         settle(4);
         wr(A_POL,  {28'b0, e[5], 3'b0});
         wr(A_TRIG, {28'b0, e[4], 3'b0});
         wr(A_DUAL, {28'b0, e[3], 3'b0});
         settle(2);
         wr(A_SWE, 32'h0000_0003);
         irq_in[3] = e[1];
         settle(6);
         rd(A_PEND, r);
         chk(e[4] ? (e[3] ? "R4 dual edge pending" : "R3 edge pending") : "R2 level pending",
             {31'b0, r[3]}, {31'b0, e[0]});
         chk("R8 pin follows vector", {26'b0, irq_pin}, e[0] ? 32'h4 : 32'h0);
      end
      irq_in = '0;
      wr(A_POL, 32'hFFFF_FFFF);
      wr(A_TRIG, 32'h0);
      wr(A_DUAL, 32'h0);
      wr(A_MCLR, 32'hFFFF_FFFF);
      wr(A_ROUTE + 11'd12, 32'h0);
      settle(6);

      // R5 software edge register
      wr(A_TRIG, 32'h80);
      wr(A_SWE, 32'h8000_0007);
      rd(A_PEND, r); chk("R5 sw set", r, 32'h80);
      wr(A_SWE, 32'h8000_00C8);
      rd(A_PEND, r); chk("R5 out of range ignored", r, 32'h80);
      wr(A_SWE, 32'h0000_0007);
      rd(A_PEND, r); chk("R5 sw clear", r, 32'h0);

      // R6 split mask registers
      wr(A_MSET, 32'h0000_00F0);
      rd(A_MASK, r); chk("R6 set", r, 32'h0000_00F0);
      wr(A_MSET, 32'h0000_0003);
      rd(A_MASK, r); chk("R6 set adds", r, 32'h0000_00F3);
      wr(A_MCLR, 32'h0000_0030);
      rd(A_MASK, r); chk("R6 clear", r, 32'h0000_00C3);
      wr(A_MCLR, 32'h0);
      rd(A_MASK, r); chk("R6 zero clear no effect", r, 32'h0000_00C3);
      wr(A_MCLR, 32'hFFFF_FFFF);

      // R11 masked source still pending, R8 routing
      wr(A_ROUTE + 11'd16, 32'h8000_0001);
      irq_in[4] = 1'b1;
      settle(6);
      rd(A_PEND, r); chk("R11 pending while masked", r, 32'h10);
      chk("R11 pin quiet while masked", {26'b0, irq_pin}, 32'h0);
      wr(A_MSET, 32'h10);
      settle(3);
      chk("R8 pin 1 driven", {26'b0, irq_pin}, 32'h2);
      wr(A_ROUTE + 11'd16, 32'h8000_003F);
      settle(3);
      chk("R8 pin out of range", {25'b0, irq_nmi, irq_pin}, 32'h0);

      // R9 NMI route
      wr(A_ROUTE + 11'd16, 32'h4000_0001);
      settle(3);
      chk("R9 nmi only", {25'b0, irq_nmi, irq_pin}, 32'h40);
      rd(A_ROUTE + 11'd16, r); chk("R9 route readback", r, 32'h4000_0001);
      wr(A_MCLR, 32'h10);
      settle(3);
      chk("R9 nmi gated by mask", {31'b0, irq_nmi}, 32'h0);
      irq_in[4] = 1'b0;

      // R10 edge and software clear in one cycle
      wr(A_TRIG, 32'h200);
      settle(4);
      @(negedge clk);
      irq_in[9] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = A_SWE; bus_wdata = 32'h0000_0009;
      @(negedge clk);
      bus_we = 1'b0;
      rd(A_PEND, r); chk("R10 edge wins over clear", {31'b0, r[9]}, 32'h1);
      wr(A_SWE, 32'h0000_0009);
      rd(A_PEND, r); chk("R10 later clear", {31'b0, r[9]}, 32'h0);

      // R7 words past the last source
      rd(A_POL + 11'd4, r);  chk("R7 polarity word 1", r, 32'h0);
      rd(A_PEND + 11'd4, r); chk("R7 pending word 1", r, 32'h0);

      finish_run();
   end
endmodule